// File: doc/BRIEF.md
# Clock Source Select and Output Controller

This block picks the system clock for a device with two possible sources: an on-chip crystal oscillator and a bidirectional system-clock pin. While the device is held in reset, the oscillator enable is low and the pin is not driven. When reset is released, the block watches the pin for a fixed window of crystal cycles. If it sees enough transitions there, it takes the pin as the source of the internal clock and leaves the pin as an input. If it does not, it takes the crystal clock and drives it out on the pin.

In crystal mode two control bits, supplied by a register block outside this one, shape what appears on the pin. One bit enables the output driver. When it is clear, the pin goes high-impedance. The other bit halves the output frequency. The choice of source holds until the next reset, and a status output reports it.

Top module: `clksel_top`

## Requirements
- R1: While `rst_n` is low, `osc_en` is 0, `pin_oe` is 0 and `ext_sel` is 0.
- R2: From reset release until the detection decision (at most WIN = 64 crystal cycles after the synchronized release), `pin_oe` stays 0.
- R3: If at least EDGES = 8 transitions (rising or falling) of `pin_in` are seen within the window, `ext_sel` becomes 1, `pin_oe` stays 0 and `int_clk` follows `pin_in`.
- R4: If fewer than 8 transitions are seen within the window, `ext_sel` stays 0 and `int_clk` follows `xtal_clk`.
- R5: In crystal mode with `oe_bit` = 1 and `div_bit` = 0, `pin_oe` is 1 and `pin_out` equals `xtal_clk`.
- R6: In crystal mode with `oe_bit` = 0, `pin_oe` is 0 and `pin_out` is 0.
- R7: With `div_bit` = 1, `pin_out` toggles on every rising edge of `xtal_clk`, which gives half the frequency at a 50% duty cycle.
- R8: A change of `div_bit` reaches `pin_out` only at the next rising edge of `xtal_clk`.
- R9: Once made, the source decision holds until the next reset, whatever activity follows on `pin_in`.
- R10: `osc_en` is 1 whenever `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low device reset |
| oe_bit | input | 1 | Register bit: enable the pin driver in crystal mode |
| div_bit | input | 1 | Register bit: halve the clock driven on the pin |
| xtal_clk | input | 1 | Clock from the crystal oscillator |
| pin_in | input | 1 | Input path of the system-clock pin |
| osc_en | output | 1 | Enable for the crystal oscillator driver |
| pin_out | output | 1 | Output data for the system-clock pin |
| pin_oe | output | 1 | Output enable for the system-clock pin |
| int_clk | output | 1 | Selected internal clock |
| ext_sel | output | 1 | Source status: 1 = pin clock, 0 = crystal |

## Verification
The transition counter and the detection state are only visible through `ext_sel` and `pin_oe`. A wrong count therefore shows as the wrong source once the window closes, 64 cycles after release, and the bench sweeps the number of pin transitions across the threshold so that an off-by-one is caught. An early enable shows as `pin_oe` high inside the window. A divider flop that is not toggling shows at once as a flat `pin_out`. An unregistered divide bit shows within half a cycle, as a change on `pin_out` during the low phase of the crystal clock.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    SRC_DETECT = 2'd0,
    SRC_XTAL   = 2'd1,
    SRC_EXT    = 2'd2
  } src_state_t;
endpackage

// File: rtl/clksel_rst_sync.sv
module clksel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/clksel_detect.sv
module clksel_detect
  import clksel_pkg::*;
#(
  parameter int WIN   = 64,
  parameter int EDGES = 8,
  parameter int SYNC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic decided,
  output logic ext_sel
);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST  = WW'(WIN - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

  logic [SYNC:0]   smp_q, smp_d;
  logic [WW-1:0]   win_q, win_d;
  logic [EW-1:0]   cnt_q, cnt_d;
  src_state_t      st_q, st_d;
  logic            edge_seen;
  logic            in_win;

  assign edge_seen = smp_q[SYNC] ^ smp_q[SYNC-1];
  assign in_win    = (st_q == SRC_DETECT);

  always_comb begin
    smp_d = {smp_q[SYNC-1:0], pin_in};
    win_d = win_q;
    cnt_d = cnt_q;
    st_d  = st_q;
    if (in_win) begin
      win_d = win_q + 1'b1;
      if (edge_seen) cnt_d = cnt_q + 1'b1;
      if (edge_seen && cnt_q == EDGE_LAST) st_d = SRC_EXT;
      else if (win_q == WIN_LAST)          st_d = SRC_XTAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      win_q <= '0;
      cnt_q <= '0;
      st_q  <= SRC_DETECT;
    end else begin
      smp_q <= smp_d;
      win_q <= win_d;
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign decided = (st_q != SRC_DETECT);
  assign ext_sel = (st_q == SRC_EXT);

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= EW'(EDGES)) else $error("edge count overflow"); // R3
  AST_EXT_NEEDS_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> cnt_q == EW'(EDGES)) else $error("ext without enough edges"); // R3
  AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    decided |=> decided && $stable(ext_sel)) else $error("source changed"); // R9
endmodule

// File: rtl/clksel_div.sv
module clksel_div (
  input  logic clk,
  input  logic rst_n,
  input  logic div_bit,
  output logic clk_out
);
  logic tog_q, tog_d;
  logic div_q, div_d;

  always_comb begin
    tog_d = ~tog_q;
    div_d = div_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      div_q <= div_d;
    end
  end

  assign clk_out = div_q ? tog_q : clk;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tog_q != $past(tog_q)) else $error("divider stuck"); // R7
endmodule

// File: rtl/clksel_top.sv
module clksel_top #(
  parameter int WIN   = 64,
  parameter int EDGES = 8,
  parameter int SYNC  = 2
) (
  input  logic rst_n,
  input  logic oe_bit,
  input  logic div_bit,
  input  logic xtal_clk,
  input  logic pin_in,
  output logic osc_en,
  output logic pin_out,
  output logic pin_oe,
  output logic int_clk,
  output logic ext_sel
);
  logic rst_s_n;
  logic decided;
  logic div_clk;

  assign osc_en = rst_n;

  clksel_rst_sync #(.STAGES(2)) u_rst (
    .clk(xtal_clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  clksel_detect #(.WIN(WIN), .EDGES(EDGES), .SYNC(SYNC)) u_det (
    .clk(xtal_clk), .rst_n(rst_s_n), .pin_in(pin_in),
    .decided(decided), .ext_sel(ext_sel)
  );

  clksel_div u_div (
    .clk(xtal_clk), .rst_n(rst_s_n), .div_bit(div_bit), .clk_out(div_clk)
  );

  assign pin_oe  = decided && !ext_sel && oe_bit && rst_n;
  assign pin_out = pin_oe ? div_clk : 1'b0;
  assign int_clk = ext_sel ? pin_in : xtal_clk;

  AST_NO_DRIVE_IN_WINDOW: assert property (@(posedge xtal_clk) disable iff (!rst_s_n)
    !decided |-> !pin_oe) else $error("pin driven during detection"); // R2
  AST_NO_DRIVE_EXT: assert property (@(posedge xtal_clk) disable iff (!rst_s_n)
    ext_sel |-> !pin_oe) else $error("pin driven against external clock"); // R3
endmodule

// File: tb/sim_clksel_top.sv
module sim_clksel_top;
  localparam int TCLK = 10;

  logic rst_n, oe_bit, div_bit, xtal_clk, pin_in;
  logic osc_en, pin_out, pin_oe, int_clk, ext_sel;
  logic ext_run;
  int   n_chk, n_err;

  clksel_top u0 (
    .rst_n(rst_n), .oe_bit(oe_bit), .div_bit(div_bit), .xtal_clk(xtal_clk),
    .pin_in(pin_in), .osc_en(osc_en), .pin_out(pin_out), .pin_oe(pin_oe),
    .int_clk(int_clk), .ext_sel(ext_sel)
  );

  initial xtal_clk = 1'b0;
  always #(TCLK/2) xtal_clk = ~xtal_clk;

  always begin
    #(2*TCLK);
    if (ext_run) pin_in = ~pin_in;
  end

  initial begin
    #(TCLK * 150000);
    n_err = n_err + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge xtal_clk);
  endtask

  task automatic do_reset();
    ext_run = 1'b0;
    @(negedge xtal_clk);
    rst_n = 1'b0;
    pin_in = 1'b0;
    cyc(3);
    #2;
    chk(osc_en, 1'b0, "R1 osc_en");
    chk(pin_oe, 1'b0, "R1 pin_oe");
    chk(ext_sel, 1'b0, "R1 ext_sel");
    @(negedge xtal_clk);
    rst_n = 1'b1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(3);
      pin_in = ~pin_in;
    end
  endtask

  initial begin
    int trans;
    logic prev;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; oe_bit = 1'b1; div_bit = 1'b0; pin_in = 1'b0; ext_run = 1'b0;

    // quiet pin: crystal mode
    do_reset();
    cyc(10); #2;
    chk(osc_en, 1'b1, "R10 osc_en after release");
    chk(pin_oe, 1'b0, "R2 no drive in window");
    cyc(80); #2;
    chk(ext_sel, 1'b0, "R4 quiet pin selects crystal");
    chk(pin_oe, 1'b1, "R5 pin driven");
    chk(pin_out, xtal_clk, "R5 pin_out low phase");
    chk(int_clk, xtal_clk, "R4 int_clk low phase");
    @(posedge xtal_clk); #2;
    chk(pin_out, 1'b1, "R5 pin_out high phase");
    chk(int_clk, 1'b1, "R4 int_clk high phase");

    // output enable off
    oe_bit = 1'b0; #1;
    chk(pin_oe, 1'b0, "R6 pin_oe off");
    chk(pin_out, 1'b0, "R6 pin_out off");
    oe_bit = 1'b1;

    // divide by two: transitions at posedge+2 samples
    div_bit = 1'b1;
    @(posedge xtal_clk); @(posedge xtal_clk); #2;
    prev = pin_out; trans = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge xtal_clk); #2;
      if (pin_out !== prev) trans++;
      prev = pin_out;
    end
    chk(trans == 20, 1'b1, "R7 divided pin toggles every rising edge");
    div_bit = 1'b0;
    @(posedge xtal_clk); @(posedge xtal_clk); #2;
    prev = pin_out; trans = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge xtal_clk); #2;
      if (pin_out !== prev) trans++;
      prev = pin_out;
    end
    chk(trans == 0, 1'b1, "R7 undivided pin high at every rising edge");

    // divide change waits for a rising edge, two phases of the toggle flop
    for (int k = 0; k < 2; k++) begin
      @(negedge xtal_clk); #2;
      div_bit = 1'b1; #1;
      chk(pin_out, 1'b0, "R8 divide change held until rising edge");
      cyc(1); #2;
      div_bit = 1'b0;
      cyc(2);
    end

    // crystal selection locked despite pin activity
    ext_run = 1'b1;
    cyc(60); #2;
    chk(ext_sel, 1'b0, "R9 crystal stays locked");
    ext_run = 1'b0;

    // sweep the transition count around the threshold
    for (int n = 0; n <= 10; n++) begin
      do_reset();
      pulses(n);
      #2;
      chk(pin_oe, 1'b0, "R2 no drive while counting");
      cyc(80); #2;
      if (n >= 8) chk(ext_sel, 1'b1, "R3 enough transitions select pin");
      else        chk(ext_sel, 1'b0, "R4 too few transitions keep crystal");
      chk(pin_oe, (n < 8) ? 1'b1 : 1'b0, "R3 pin_oe follows source");
    end

    // free-running external clock, then lock and follow
    do_reset();
    ext_run = 1'b1;
    cyc(80); #2;
    chk(ext_sel, 1'b1, "R3 running pin clock selected");
    chk(pin_oe, 1'b0, "R3 pin not driven");
    ext_run = 1'b0;
    #(3*TCLK);
    pin_in = 1'b1; #1;
    chk(int_clk, 1'b1, "R3 int_clk follows pin high");
    pin_in = 1'b0; #1;
    chk(int_clk, 1'b0, "R3 int_clk follows pin low");
    cyc(100); #2;
    chk(ext_sel, 1'b1, "R9 pin selection locked after clock stops");
    chk(pin_oe, 1'b0, "R9 pin still not driven");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule